// File: doc/BRIEF.md
# Shadow Stack Atomic Swap Unit

This unit carries out the shadow-stack swap instruction for a core built with a 32-bit or a 64-bit register width. It takes in one decoded request: the operand width, the current privilege level and virtualization bit, the target address, the source register value, the destination register index and the two ordering bits. It also receives the per-level enable bits, the supervisor-present configuration bit and two attribute flags from address translation. It first decides whether the request must trap, and which exception class applies. Only a request that passes every check reaches memory.

A request that passes runs one locked transaction on a simple memory port. The unit reads the old value and then writes the new value to the same address, and holds the lock from the read request until the write is accepted. It then returns the old value, formatted for the destination register, in a single-cycle response. The acquire and release bits travel with both memory phases as sideband signals. Translation, coherence and the real ordering machinery are outside the unit.

Top module: `ss_swap_unit`

## Requirements
- R1: A request whose privilege level is below machine (`req_priv` not 3) while `en_m` is 0 responds with cause 1 (illegal instruction).
- R2: With `cfg_s_present` at 0, every request, machine level included, responds with cause 1.
- R3: The checks apply in this order, and the first one that matches decides the cause: width, R1, R2, user level (`req_priv`=0, `req_virt`=0) with `en_s`=0 gives cause 1, virtual supervisor (`req_priv`=1, `req_virt`=1) with `en_h`=0 gives cause 2 (virtual instruction), virtual user (`req_priv`=0, `req_virt`=1) with `en_s`=0 gives cause 2, then the R5 and R6 memory checks.
- R4: With XLEN=32, a doubleword request (`req_dword`=1) responds with cause 1 before any other check.
- R5: A word address with bits [1:0] not zero, a doubleword address with bits [2:0] not zero, or `req_idem`=0 responds with cause 3 (store/AMO access fault). Misalignment is checked before idempotence.
- R6: When the checks above pass, a machine-level request responds with cause 3. Otherwise `req_ss_page`=0 responds with cause 4 (store/AMO page fault). Cause 0 means no exception.
- R7: A request with a nonzero cause produces no memory request and no write-back, and its response arrives on the clock edge after acceptance.
- R8: With XLEN=64, a word swap writes `req_src[31:0]` to the addressed word and leaves the other half of the doubleword unchanged. The response carries the old word sign-extended from bit 31. Word data sits in bits [31:0] of both memory data buses.
- R9: With XLEN=64, a doubleword swap writes the full 64-bit source and returns the full old 64-bit value.
- R10: With XLEN=32, a word swap returns the 32-bit old value unchanged and writes the 32-bit source.
- R11: When `req_rd` is 0, `rsp_wb_en` stays 0 and `rsp_data` is 0. When there is no write-back, `rsp_data` is always 0.
- R12: A swap issues exactly one read and then one write to the same address. `mem_lock` is high from the read request until the write is accepted. A request held while `mem_req_ready` is low keeps its address, direction and data.
- R13: `mem_aq` and `mem_rl` equal the request's `req_aq` and `req_rl` during both memory phases.
- R14: After reset, `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0. Each accepted request yields exactly one `rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_s_present | input | 1 | Supervisor level is implemented |
| en_m | input | 1 | Machine-level shadow-stack enable |
| en_s | input | 1 | Supervisor-level enable (for user and virtual user) |
| en_h | input | 1 | Hypervisor-level enable (for virtual supervisor) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and accepting |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Virtualization active |
| req_addr | input | XLEN | Target address |
| req_src | input | XLEN | Value to store |
| req_rd | input | 5 | Destination register index |
| req_aq | input | 1 | Acquire bit |
| req_rl | input | 1 | Release bit |
| req_idem | input | 1 | Target memory is idempotent |
| req_ss_page | input | 1 | Target page carries the shadow-stack attribute |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_lock | output | 1 | Port locked for this swap |
| mem_dword | output | 1 | Access size is a doubleword |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Write data, word in [31:0] |
| mem_aq | output | 1 | Acquire sideband |
| mem_rl | output | 1 | Release sideband |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Read data, word in [31:0] |
| rsp_valid | output | 1 | Response pulse |
| rsp_cause | output | 3 | Exception cause, 0 = none |
| rsp_wb_en | output | 1 | Write rsp_data to rsp_rd |
| rsp_rd | output | 5 | Destination register index |
| rsp_data | output | XLEN | Old memory value, formatted |

## Verification
If the sequencer goes wrong, it shows in the memory traffic within one transaction. A fault that still touches memory breaks the zero-access count on the next response. A write that comes before its read, or on a different address, corrupts the model's memory at the next swap. A lock released early fires the lock check on the same cycle. A wrong check priority or width format shows up in the very response it affects, because every response is compared against a cause and a value computed from the requirements. Stalls on ready and delays on read data are drawn at random, so a state that mishandles back-pressure hangs or misreads within a few cycles.

// File: rtl/ssw_pkg.sv
// Shared types for the shadow-stack swap unit.
// Assumes: cause codes are visible at the top-level port as 3-bit values.
package ssw_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_ILLEGAL = 3'd1,
        CAUSE_VIRTUAL = 3'd2,
        CAUSE_ACCESS  = 3'd3,
        CAUSE_PAGE    = 3'd4
    } cause_e;

    typedef enum logic [2:0] {
        SW_IDLE    = 3'd0,
        SW_RD_REQ  = 3'd1,
        SW_RD_WAIT = 3'd2,
        SW_WR_REQ  = 3'd3,
        SW_RESP    = 3'd4
    } sw_state_e;

    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_SUPER = 2'd1;
    localparam logic [1:0] LVL_MACH  = 2'd3;

endpackage

// File: rtl/ssw_exc_check.sv
// Exception resolver: a purely combinational priority chain that turns
// the request attributes into one cause code.
// Assumes: XLEN is 32 or 64; priv value 2 is never driven.
module ssw_exc_check
    import ssw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic       dword,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic [2:0] addr_lo,
    input  logic       idem,
    input  logic       ss_page,
    input  logic       s_present,
    input  logic       en_m,
    input  logic       en_s,
    input  logic       en_h,
    output cause_e     cause
);
    localparam bit HAS_DWORD = (XLEN == 64);

    logic lvl_m, lvl_u, lvl_vs, lvl_vu, misaligned;

    // Classify the effective level and the alignment of the target
    always_comb begin
        lvl_m      = (priv == LVL_MACH);
        lvl_u      = (priv == LVL_USER)  && !virt;
        lvl_vs     = (priv == LVL_SUPER) && virt;
        lvl_vu     = (priv == LVL_USER)  && virt;
        misaligned = dword ? (addr_lo != 3'b000) : (addr_lo[1:0] != 2'b00);
    end

    // First matching check decides the cause
    always_comb begin
        if (dword && !HAS_DWORD)        cause = CAUSE_ILLEGAL;
        else if (!lvl_m && !en_m)       cause = CAUSE_ILLEGAL;
        else if (!s_present)            cause = CAUSE_ILLEGAL;
        else if (lvl_u && !en_s)        cause = CAUSE_ILLEGAL;
        else if (lvl_vs && !en_h)       cause = CAUSE_VIRTUAL;
        else if (lvl_vu && !en_s)       cause = CAUSE_VIRTUAL;
        else if (misaligned)            cause = CAUSE_ACCESS;
        else if (!idem)                 cause = CAUSE_ACCESS;
        else if (lvl_m)                 cause = CAUSE_ACCESS;
        else if (!ss_page)              cause = CAUSE_PAGE;
        else                            cause = CAUSE_NONE;
    end

endmodule

// File: rtl/ssw_data_fmt.sv
// Data formatter: places store data on the memory bus and shapes the
// loaded value for the destination register, per register width.
// Assumes: word data travels in bits [31:0] of both data buses.
module ssw_data_fmt #(
    parameter int XLEN = 64
) (
    input  logic            dword,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] load_val
);
    localparam int UPPER = XLEN - 32;

    generate
        if (XLEN == 64) begin : g_wide
            // Word forms sign-extend the load and zero the unused store bits
            always_comb begin
                if (dword) begin
                    wdata    = src;
                    load_val = rdata;
                end else begin
                    wdata    = {{UPPER{1'b0}}, src[31:0]};
                    load_val = {{UPPER{rdata[31]}}, rdata[31:0]};
                end
            end
        end else begin : g_narrow
            // Only the word form exists; a doubleword never reaches memory
            always_comb begin
                wdata    = src;
                load_val = dword ? '0 : rdata;
            end
        end
    endgenerate

endmodule

// File: rtl/ssw_seq.sv
// Swap sequencer: accepts one request, then either answers at once with
// a fault or runs a locked read followed by a write on the memory port.
// Assumes: read data may arrive any number of cycles after the read is
// accepted; the write is complete when it is accepted.
module ssw_seq
    import ssw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      fault,
    input  logic      mem_req_ready,
    input  logic      mem_rsp_valid,
    output logic      req_ready,
    output logic      mem_req_valid,
    output logic      mem_we,
    output logic      mem_lock,
    output logic      rd_capture,
    output logic      rsp_valid
);
    sw_state_e state_q, state_d;

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            SW_IDLE:    if (start) state_d = fault ? SW_RESP : SW_RD_REQ;
            SW_RD_REQ:  if (mem_req_ready) state_d = SW_RD_WAIT;
            SW_RD_WAIT: if (mem_rsp_valid) state_d = SW_WR_REQ;
            SW_WR_REQ:  if (mem_req_ready) state_d = SW_RESP;
            SW_RESP:    state_d = SW_IDLE;
            default:    state_d = SW_IDLE;
        endcase
    end

    // Decoded control outputs
    always_comb begin
        req_ready     = (state_q == SW_IDLE);
        mem_req_valid = (state_q == SW_RD_REQ) || (state_q == SW_WR_REQ);
        mem_we        = (state_q == SW_WR_REQ);
        mem_lock      = (state_q == SW_RD_REQ) || (state_q == SW_RD_WAIT)
                     || (state_q == SW_WR_REQ);
        rd_capture    = (state_q == SW_RD_WAIT) && mem_rsp_valid;
        rsp_valid     = (state_q == SW_RESP);
    end

endmodule

// File: rtl/ss_swap_unit.sv
// Shadow-stack swap unit top: latches a request, resolves its exception
// class, runs the locked read/write on the memory port and returns the
// old value in a one-cycle response.
// Assumes: enables and attribute flags are valid with req_valid.
module ss_swap_unit
    import ssw_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_s_present,
    input  logic              en_m,
    input  logic              en_s,
    input  logic              en_h,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_dword,
    input  logic [1:0]        req_priv,
    input  logic              req_virt,
    input  logic [XLEN-1:0]   req_addr,
    input  logic [XLEN-1:0]   req_src,
    input  logic [RIDX_W-1:0] req_rd,
    input  logic              req_aq,
    input  logic              req_rl,
    input  logic              req_idem,
    input  logic              req_ss_page,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_we,
    output logic              mem_lock,
    output logic              mem_dword,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_aq,
    output logic              mem_rl,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_cause,
    output logic              rsp_wb_en,
    output logic [RIDX_W-1:0] rsp_rd,
    output logic [XLEN-1:0]   rsp_data
);
    cause_e            chk_cause;
    cause_e            r_cause;
    logic              r_dword, r_aq, r_rl;
    logic [XLEN-1:0]   r_addr, r_src, r_ldata;
    logic [RIDX_W-1:0] r_rd;
    logic [XLEN-1:0]   fmt_load;
    logic              start, rd_capture;

    assign start = req_valid && req_ready;

    ssw_exc_check #(.XLEN(XLEN)) u_check (
        .dword     (req_dword),
        .priv      (req_priv),
        .virt      (req_virt),
        .addr_lo   (req_addr[2:0]),
        .idem      (req_idem),
        .ss_page   (req_ss_page),
        .s_present (cfg_s_present),
        .en_m      (en_m),
        .en_s      (en_s),
        .en_h      (en_h),
        .cause     (chk_cause)
    );

    ssw_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .fault         (chk_cause != CAUSE_NONE),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_we        (mem_we),
        .mem_lock      (mem_lock),
        .rd_capture    (rd_capture),
        .rsp_valid     (rsp_valid)
    );

    ssw_data_fmt #(.XLEN(XLEN)) u_fmt (
        .dword    (r_dword),
        .src      (r_src),
        .rdata    (mem_rdata),
        .wdata    (mem_wdata),
        .load_val (fmt_load)
    );

    // Latch the request and its resolved cause on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_cause <= CAUSE_NONE;
            r_dword <= 1'b0;
            r_aq    <= 1'b0;
            r_rl    <= 1'b0;
            r_addr  <= '0;
            r_src   <= '0;
            r_rd    <= '0;
        end else if (start) begin
            r_cause <= chk_cause;
            r_dword <= req_dword;
            r_aq    <= req_aq;
            r_rl    <= req_rl;
            r_addr  <= req_addr;
            r_src   <= req_src;
            r_rd    <= req_rd;
        end
    end

    // Hold the formatted old value once read data arrives
    always_ff @(posedge clk) begin
        if (!rst_n)          r_ldata <= '0;
        else if (start)      r_ldata <= '0;
        else if (rd_capture) r_ldata <= fmt_load;
    end

    // Memory-side address and sideband, driven only during a phase
    always_comb begin
        mem_addr  = r_addr;
        mem_dword = r_dword;
        mem_aq    = mem_req_valid && r_aq;
        mem_rl    = mem_req_valid && r_rl;
    end

    // Response fields
    always_comb begin
        rsp_cause = r_cause;
        rsp_rd    = r_rd;
        rsp_wb_en = rsp_valid && (r_cause == CAUSE_NONE) && (r_rd != '0);
        rsp_data  = rsp_wb_en ? r_ldata : '0;
    end

endmodule

// File: rtl/ss_swap_unit_sva.sv
// Protocol checker for the swap unit, bound onto every instance.
// Assumes: reset is synchronous active-low on clk.
module ss_swap_unit_sva #(
    parameter int XLEN = 64,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_we,
    input logic              mem_lock,
    input logic              mem_dword,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              rsp_valid,
    input logic [2:0]        rsp_cause,
    input logic              rsp_wb_en,
    input logic [RIDX_W-1:0] rsp_rd
);
    assert_lock_cover_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_lock);

    assert_unlock_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> $past(mem_req_valid && mem_req_ready && mem_we));

    assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)
            && $stable(mem_we) && $stable(mem_wdata)));

    assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_dword ? (mem_addr[2:0] == 3'b000) : (mem_addr[1:0] == 2'b00)));

    assert_no_dword_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_dword) |-> (XLEN == 64));

    assert_fault_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 3'd0) |-> !rsp_wb_en);

    assert_x0_no_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb_en |-> (rsp_valid && rsp_rd != '0));

    assert_single_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_mem_while_resp_R14: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req_valid);

endmodule

bind ss_swap_unit ss_swap_unit_sva #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_lock      (mem_lock),
    .mem_dword     (mem_dword),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_cause     (rsp_cause),
    .rsp_wb_en     (rsp_wb_en),
    .rsp_rd        (rsp_rd)
);

// File: tb/ss_swap_unit_tb.sv
module ss_swap_unit_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    logic        cfg_s_present, en_m, en_s, en_h;
    logic        req_valid, req_ready, req_dword, req_virt;
    logic [1:0]  req_priv;
    logic [63:0] req_addr, req_src;
    logic [4:0]  req_rd;
    logic        req_aq, req_rl, req_idem, req_ss_page;
    logic        mem_req_valid, mem_req_ready, mem_we, mem_lock, mem_dword;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_aq, mem_rl, mem_rsp_valid;
    logic        rsp_valid, rsp_wb_en;
    logic [2:0]  rsp_cause;
    logic [4:0]  rsp_rd;
    logic [63:0] rsp_data;

    ss_swap_unit #(.XLEN(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_s_present(cfg_s_present),
        .en_m(en_m), .en_s(en_s), .en_h(en_h),
        .req_valid(req_valid), .req_ready(req_ready), .req_dword(req_dword),
        .req_priv(req_priv), .req_virt(req_virt), .req_addr(req_addr),
        .req_src(req_src), .req_rd(req_rd), .req_aq(req_aq), .req_rl(req_rl),
        .req_idem(req_idem), .req_ss_page(req_ss_page),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_we(mem_we), .mem_lock(mem_lock), .mem_dword(mem_dword),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_aq(mem_aq),
        .mem_rl(mem_rl), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_wb_en(rsp_wb_en),
        .rsp_rd(rsp_rd), .rsp_data(rsp_data)
    );

    // Narrow instance with a fixed-data responder
    logic        n_valid, n_ready, n_dword, n_mreq, n_mwe, n_lock, n_mdw;
    logic [31:0] n_addr, n_src, n_maddr, n_mwdata;
    logic        n_maq, n_mrl, n_rspv, n_rsp_valid, n_wb;
    logic [2:0]  n_cause;
    logic [4:0]  n_rd;
    logic [31:0] n_data;
    logic [31:0] n_wr_seen;
    int          n_acc;
    localparam logic [31:0] N_RDATA = 32'hF0E1_D2C3;

    ss_swap_unit #(.XLEN(32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .cfg_s_present(1'b1),
        .en_m(1'b1), .en_s(1'b1), .en_h(1'b1),
        .req_valid(n_valid), .req_ready(n_ready), .req_dword(n_dword),
        .req_priv(2'd0), .req_virt(1'b0), .req_addr(n_addr),
        .req_src(n_src), .req_rd(5'd9), .req_aq(1'b0), .req_rl(1'b0),
        .req_idem(1'b1), .req_ss_page(1'b1),
        .mem_req_valid(n_mreq), .mem_req_ready(1'b1),
        .mem_we(n_mwe), .mem_lock(n_lock), .mem_dword(n_mdw),
        .mem_addr(n_maddr), .mem_wdata(n_mwdata), .mem_aq(n_maq),
        .mem_rl(n_mrl), .mem_rsp_valid(n_rspv), .mem_rdata(N_RDATA),
        .rsp_valid(n_rsp_valid), .rsp_cause(n_cause), .rsp_wb_en(n_wb),
        .rsp_rd(n_rd), .rsp_data(n_data)
    );

    // Narrow responder: read data one cycle after the read is accepted
    always @(posedge clk) begin
        if (!rst_n) begin
            n_rspv    <= 1'b0;
            n_wr_seen <= '0;
            n_acc     <= 0;
        end else begin
            n_rspv <= n_mreq && !n_mwe;
            if (n_mreq) n_acc <= n_acc + 1;
            if (n_mreq && n_mwe) n_wr_seen <= n_mwdata;
        end
    end

    // Wide memory model, stalls and delays drawn at random
    logic [63:0] mem [0:15];
    int          mem_acc = 0;
    logic        rd_pend = 1'b0;
    int          rd_delay = 0;
    logic [63:0] rd_val;
    logic        seen_aq, seen_rl, seen_wr_addr_ok;
    logic [63:0] seen_rd_addr;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rd_pend) begin
            if (rd_delay == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rdata     = rd_val;
                rd_pend       = 1'b0;
            end else begin
                rd_delay = rd_delay - 1;
            end
        end
        mem_req_ready = (($urandom % 3) != 0);
        if (rst_n && mem_req_valid && mem_req_ready) begin
            mem_acc = mem_acc + 1;
            seen_aq = seen_aq && mem_aq;
            seen_rl = seen_rl && mem_rl;
            if (!mem_we) begin
                seen_rd_addr = mem_addr;
                rd_pend  = 1'b1;
                rd_delay = int'($urandom % 3);
                if (mem_dword)        rd_val = mem[mem_addr[6:3]];
                else if (mem_addr[2]) rd_val = {~mem[mem_addr[6:3]][63:32], mem[mem_addr[6:3]][63:32]};
                else                  rd_val = {~mem[mem_addr[6:3]][31:0], mem[mem_addr[6:3]][31:0]};
            end else begin
                seen_wr_addr_ok = (mem_addr == seen_rd_addr);
                if (mem_dword)        mem[mem_addr[6:3]] = mem_wdata;
                else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] = mem_wdata[31:0];
                else                  mem[mem_addr[6:3]][31:0]  = mem_wdata[31:0];
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cause expected from the ordered checks in the requirements
    function automatic logic [2:0] exp_cause(input logic dw, input logic [1:0] pv, input logic vt,
                                             input logic [2:0] lo, input logic idem, input logic ssp,
                                             input logic sp, input logic em, input logic es, input logic eh);
        logic m, u, vs, vu, mis;
        m  = (pv == 2'd3);
        u  = (pv == 2'd0) && !vt;
        vs = (pv == 2'd1) && vt;
        vu = (pv == 2'd0) && vt;
        mis = dw ? (lo != 3'b000) : (lo[1:0] != 2'b00);
        if (!m && !em)      return 3'd1;
        if (!sp)            return 3'd1;
        if (u && !es)       return 3'd1;
        if (vs && !eh)      return 3'd2;
        if (vu && !es)      return 3'd2;
        if (mis || !idem)   return 3'd3;
        if (m)              return 3'd3;
        if (!ssp)           return 3'd4;
        return 3'd0;
    endfunction

    function automatic string cause_tag(input logic [2:0] c);
        case (c)
            3'd1: return "R1";
            3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R8";
        endcase
    endfunction

    // One swap on the wide instance, with full checking of its outcome
    task automatic swap(input logic dw, input logic [1:0] pv, input logic vt,
                        input logic [63:0] ad, input logic [63:0] sr, input logic [4:0] rd,
                        input logic aq, input logic rl, input logic idem, input logic ssp,
                        input string tag);
        logic [2:0]  ec;
        logic [63:0] old, exp_mem, exp_ld;
        int          acc0, waited;
        @(negedge clk);
        ec   = exp_cause(dw, pv, vt, ad[2:0], idem, ssp, cfg_s_present, en_m, en_s, en_h);
        old  = mem[ad[6:3]];
        acc0 = mem_acc;
        seen_aq = 1'b1; seen_rl = 1'b1; seen_wr_addr_ok = 1'b0;
        if (dw)         begin exp_ld = old; exp_mem = sr; end
        else if (ad[2]) begin exp_ld = {{32{old[63]}}, old[63:32]}; exp_mem = {sr[31:0], old[31:0]}; end
        else            begin exp_ld = {{32{old[31]}}, old[31:0]};  exp_mem = {old[63:32], sr[31:0]}; end
        if (rd == 5'd0) exp_ld = 64'd0;
        req_valid = 1'b1; req_dword = dw; req_priv = pv; req_virt = vt;
        req_addr = ad; req_src = sr; req_rd = rd; req_aq = aq; req_rl = rl;
        req_idem = idem; req_ss_page = ssp;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!rsp_valid && waited < 200) begin
            @(negedge clk);
            waited = waited + 1;
        end
        check(rsp_valid, {tag, " response R14"}, 64'(rsp_valid), 64'd1);
        check(rsp_cause == ec, {tag, " cause ", cause_tag(ec)}, 64'(rsp_cause), 64'(ec));
        if (ec != 3'd0) begin
            check(waited == 0, {tag, " fault latency R7"}, 64'(waited), 64'd0);
            check(mem_acc == acc0, {tag, " no access R7"}, 64'(mem_acc - acc0), 64'd0);
            check(!rsp_wb_en && rsp_data == 64'd0, {tag, " no wb R7"}, rsp_data, 64'd0);
            check(mem[ad[6:3]] == old, {tag, " memory kept R7"}, mem[ad[6:3]], old);
        end else begin
            check(mem_acc - acc0 == 2, {tag, " read+write R12"}, 64'(mem_acc - acc0), 64'd2);
            check(seen_wr_addr_ok, {tag, " same address R12"}, 64'(seen_wr_addr_ok), 64'd1);
            check(rsp_wb_en == (rd != 5'd0), {tag, " wb enable R11"}, 64'(rsp_wb_en), 64'(rd != 5'd0));
            check(rsp_data == exp_ld, {tag, dw ? " load R9" : " load R8"}, rsp_data, exp_ld);
            check(mem[ad[6:3]] == exp_mem, {tag, dw ? " store R9" : " store R8"}, mem[ad[6:3]], exp_mem);
            check(seen_aq == aq && seen_rl == rl, {tag, " sideband R13"},
                  64'({seen_aq, seen_rl}), 64'({aq, rl}));
        end
    endtask

    task automatic narrow(input logic dw, input logic [31:0] ad, input logic [31:0] sr, input string tag);
        int a0, waited;
        @(negedge clk);
        a0 = n_acc;
        n_valid = 1'b1; n_dword = dw; n_addr = ad; n_src = sr;
        @(negedge clk);
        n_valid = 1'b0;
        waited = 0;
        while (!n_rsp_valid && waited < 50) begin
            @(negedge clk);
            waited = waited + 1;
        end
        if (dw) begin
            check(n_cause == 3'd1, {tag, " narrow dword illegal R4"}, 64'(n_cause), 64'd1);
            check(n_acc == a0, {tag, " narrow no access R4"}, 64'(n_acc - a0), 64'd0);
        end else begin
            check(n_cause == 3'd0, {tag, " narrow cause R10"}, 64'(n_cause), 64'd0);
            check(n_data == N_RDATA, {tag, " narrow load R10"}, 64'(n_data), 64'(N_RDATA));
            check(n_wr_seen == sr, {tag, " narrow store R10"}, 64'(n_wr_seen), 64'(sr));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
        cfg_s_present = 1'b1; en_m = 1'b1; en_s = 1'b1; en_h = 1'b1;
        req_valid = 1'b0; req_dword = 1'b0; req_priv = 2'd0; req_virt = 1'b0;
        req_addr = '0; req_src = '0; req_rd = '0; req_aq = 1'b0; req_rl = 1'b0;
        req_idem = 1'b1; req_ss_page = 1'b1;
        n_valid = 1'b0; n_dword = 1'b0; n_addr = '0; n_src = '0;
        mem_rdata = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "reset ready R14", 64'(req_ready), 64'd1);
        check(!mem_req_valid && !rsp_valid, "reset idle R14",
              64'({mem_req_valid, rsp_valid}), 64'd0);

        // Directed corner cases
        mem[2] = 64'h1234_5678_9ABC_DEF0;
        swap(1'b0, 2'd0, 1'b0, 64'h8000_0010, 64'hAAAA_BBBB_CCCC_DDDD, 5'd5, 1'b1, 1'b0, 1'b1, 1'b1, "negword R8");
        swap(1'b0, 2'd1, 1'b0, 64'h8000_0014, 64'h0000_0000_7654_3210, 5'd6, 1'b0, 1'b1, 1'b1, 1'b1, "upperword R8");
        swap(1'b1, 2'd1, 1'b1, 64'h8000_0028, 64'hFEED_FACE_0BAD_F00D, 5'd7, 1'b1, 1'b1, 1'b1, 1'b1, "dword R9");
        swap(1'b1, 2'd0, 1'b0, 64'h8000_0030, 64'h1111_2222_3333_4444, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, "x0 R11");
        swap(1'b1, 2'd0, 1'b0, 64'h8000_0034, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "misaligned R5");
        swap(1'b0, 2'd0, 1'b0, 64'h8000_0002, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "misaligned word R5");
        swap(1'b0, 2'd0, 1'b0, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, "nonidem R5");
        swap(1'b0, 2'd3, 1'b0, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "machine R6");
        swap(1'b0, 2'd1, 1'b0, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0, "notss R6");
        en_m = 1'b0;
        swap(1'b0, 2'd1, 1'b0, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "menable R1");
        swap(1'b0, 2'd3, 1'b0, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "machine ok-enable R6");
        en_m = 1'b1; cfg_s_present = 1'b0;
        swap(1'b0, 2'd3, 1'b0, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "nosuper R2");
        cfg_s_present = 1'b1; en_s = 1'b0;
        swap(1'b0, 2'd0, 1'b0, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "user R3");
        swap(1'b0, 2'd0, 1'b1, 64'h8000_0002, 64'h1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, "vuser R3");
        en_s = 1'b1; en_h = 1'b0;
        swap(1'b0, 2'd1, 1'b1, 64'h8000_0008, 64'h1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, "vsuper R3");
        en_h = 1'b1;

        narrow(1'b0, 32'h0000_0040, 32'h89AB_CDEF, "word");
        narrow(1'b1, 32'h0000_0048, 32'h1234_5678, "dword");

        // Constrained random traffic
        for (int i = 0; i < 400; i++) begin
            logic [1:0] pv;
            logic [2:0] lo;
            logic       dw;
            case ($urandom % 3)
                0: pv = 2'd0;
                1: pv = 2'd1;
                default: pv = 2'd3;
            endcase
            dw = 1'($urandom % 2);
            lo = (($urandom % 4) == 0) ? 3'($urandom) : (dw ? 3'b000 : {1'($urandom), 2'b00});
            cfg_s_present = (($urandom % 20) != 0);
            en_m = (($urandom % 8) != 0);
            en_s = (($urandom % 8) != 0);
            en_h = (($urandom % 8) != 0);
            swap(dw, pv, (($urandom % 3) == 0), {57'h100_0000, 4'($urandom), lo} , {$urandom, $urandom},
                 (($urandom % 8) == 0) ? 5'd0 : 5'($urandom), 1'($urandom), 1'($urandom),
                 (($urandom % 10) != 0), (($urandom % 10) != 0), "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule